// File: doc/BRIEF.md
# Banked Register Window Controller

This block is the register-access front end of a monitoring device. A simple synchronous register bus carries accesses into a flat 8-bit address space. The block maps the lower part of that space onto one of several register banks, picked by a bank-select register. Any controller that sits above the block, such as a serial-bus slave, talks to this bus.

A few addresses look the same whichever bank is selected. These are the bank-select register itself and three identification registers. Every other implemented address is forwarded to the bank that is currently selected. The write strobe goes to that one bank only, and read data is taken back from that bank alone. A bank number outside the implemented range is rejected, so the selection can never point at a bank that does not exist. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `bank_window_ctrl`

## Requirements
- R1: After reset, bank 0 is selected, and a read of address 0xFF returns 0x00.
- R2: A write of a value from 0 to 4 to address 0xFF selects that bank, in any bank. A read of 0xFF returns the bank number in bits [2:0] and zero in bits [7:3].
- R3: A write of a value above 4 to address 0xFF is ignored, and the previously selected bank stays selected.
- R4: In every bank, address 0x7A reads 0x50, address 0x7B reads 0xC5, and address 0x7C reads 0x5 in its upper nibble with the DEV_REV parameter (default 0x3) in its lower nibble. Writes to these three addresses change nothing.
- R5: A write to a window address (0x00 to WIN_DEPTH-1, default 0x6F) raises only the `bank_wr` bit of the selected bank, in the same cycle. It forwards the address and data unchanged on `bank_addr` and `bank_wdata`.
- R6: A read of a window address returns the selected bank's `bank_rdata` byte on `reg_rdata` in the cycle after the read strobe.
- R7: A read of any other address returns 0x00. A write to any other address raises no `bank_wr` bit.
- R8: A 16-bit quantity held as the high byte at N and the low byte at N+1 is returned as two single-byte reads, high byte first.
- R9: `reg_rdata` holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| bank_wr | output | NUM_BANKS | Per-bank write strobe |
| bank_addr | output | 8 | Address forwarded to the banks |
| bank_wdata | output | 8 | Write data forwarded to the banks |
| bank_rdata | input | NUM_BANKS*8 | Read data of every bank, bank b in bits [8b+7:8b] |

## Verification
Some properties are checked by assertions on every cycle:
- at most one bank write strobe is active, and only during a bus write;
- the selection never leaves the implemented range and does not move on an out-of-range write;
- the fixed values of the mirrored ID registers and the zero result of unimplemented reads;
- read data holding between reads.

Other properties need the bench's scenarios. Data written to one bank must not be seen from another, so the bench writes distinct patterns to each bank and reads them back. The bench also shows that the select register and the ID registers stay reachable after switching banks, and that a 16-bit pair comes back in byte order.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    localparam logic [7:0] SEL_ADDR = 8'hFF;
    localparam logic [7:0] VID_ADDR = 8'h7A;
    localparam logic [7:0] CID_ADDR = 8'h7B;
    localparam logic [7:0] DID_ADDR = 8'h7C;

    localparam logic [7:0] VID_VAL  = 8'h50;
    localparam logic [7:0] CID_VAL  = 8'hC5;
    localparam logic [3:0] DID_HIGH = 4'h5;

    typedef enum logic [2:0] {
        RG_WIN,
        RG_SEL,
        RG_VID,
        RG_CID,
        RG_DID,
        RG_NONE
    } region_e;

    // Mirrored addresses take precedence over the banked window.
    function automatic region_e classify(input logic [7:0] a, input int unsigned win_depth);
        if (a == SEL_ADDR)                return RG_SEL;
        else if (a == VID_ADDR)           return RG_VID;
        else if (a == CID_ADDR)           return RG_CID;
        else if (a == DID_ADDR)           return RG_DID;
        else if (int'(a) < win_depth)     return RG_WIN;
        else                              return RG_NONE;
    endfunction

endpackage

// File: rtl/bwc_decode.sv
module bwc_decode
    import bwc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int WIN_DEPTH = 112,
    parameter int SEL_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           addr,
    input  logic                 wr,
    input  logic [SEL_W-1:0]     cur_bank,
    output region_e              region,
    output logic                 sel_wr,
    output logic [NUM_BANKS-1:0] bank_wr
);

    always_comb begin
        region = classify(addr, WIN_DEPTH);
        sel_wr = wr && (region == RG_SEL);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
        assign bank_wr[b] = wr && (region == RG_WIN) && (int'(cur_bank) == b);
    end

    // R5: never more than one bank written at a time
    a_r5_onehot_wr: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_wr));

    // R5 / R7: a bank strobe only appears during a bus write
    a_r7_wr_needs_bus: assert property (@(posedge clk) disable iff (rst)
        (bank_wr != '0) |-> wr);

endmodule

// File: rtl/bwc_bank_sel.sv
module bwc_bank_sel #(
    parameter int NUM_BANKS = 5,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [7:0]       wdata,
    output logic [SEL_W-1:0] cur_bank
);

    logic accept;

    always_comb accept = sel_wr && (int'(wdata) < NUM_BANKS);

    always_ff @(posedge clk) begin
        if (rst)
            cur_bank <= '0;
        else if (accept)
            cur_bank <= wdata[SEL_W-1:0];
    end

    // R1: bank 0 right after reset
    a_r1_reset_bank0: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_bank == '0));

    // R3: selection always inside the implemented range
    a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(cur_bank) < NUM_BANKS);

    // R3: out-of-range select writes leave the selection alone
    a_r3_ignore_high: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && int'(wdata) >= NUM_BANKS) |=> $stable(cur_bank));

endmodule

// File: rtl/bwc_rdmux.sv
module bwc_rdmux
    import bwc_pkg::*;
#(
    parameter int         NUM_BANKS = 5,
    parameter int         SEL_W     = 3,
    parameter logic [3:0] DEV_REV   = 4'h3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd,
    input  region_e                region,
    input  logic [SEL_W-1:0]       cur_bank,
    input  logic [NUM_BANKS*8-1:0] bank_rdata,
    output logic [7:0]             rdata
);

    localparam int PAD_W = 8 - SEL_W;

    logic [7:0] bank_byte [NUM_BANKS];
    logic [7:0] win_byte;
    logic [7:0] next_byte;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
        assign bank_byte[b] = bank_rdata[b*8 +: 8];
    end

    always_comb begin
        win_byte = 8'h00;
        for (int b = 0; b < NUM_BANKS; b++)
            if (int'(cur_bank) == b) win_byte = bank_byte[b];
    end

    always_comb begin
        unique case (region)
            RG_WIN:  next_byte = win_byte;
            RG_SEL:  next_byte = {{PAD_W{1'b0}}, cur_bank};
            RG_VID:  next_byte = VID_VAL;
            RG_CID:  next_byte = CID_VAL;
            RG_DID:  next_byte = {DID_HIGH, DEV_REV};
            default: next_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 8'h00;
        else if (rd)
            rdata <= next_byte;
    end

    // R4: vendor identification is fixed in every bank
    a_r4_vendor_id: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RG_VID) |=> (rdata == 8'h50));

    // R4: chip identification is fixed in every bank
    a_r4_chip_id: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RG_CID) |=> (rdata == 8'hC5));

    // R7: unimplemented reads return zero
    a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RG_NONE) |=> (rdata == 8'h00));

    // R2: upper bits of the select readback are zero
    a_r2_sel_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RG_SEL) |=> (rdata[7:SEL_W] == '0));

    // R9: read data holds without a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/bank_window_ctrl.sv
module bank_window_ctrl
    import bwc_pkg::*;
#(
    parameter int         NUM_BANKS = 5,
    parameter int         WIN_DEPTH = 112,
    parameter logic [3:0] DEV_REV   = 4'h3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [7:0]             reg_addr,
    input  logic [7:0]             reg_wdata,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    output logic [7:0]             reg_rdata,
    output logic [NUM_BANKS-1:0]   bank_wr,
    output logic [7:0]             bank_addr,
    output logic [7:0]             bank_wdata,
    input  logic [NUM_BANKS*8-1:0] bank_rdata
);

    localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    region_e          region;
    logic             sel_wr;
    logic [SEL_W-1:0] cur_bank;

    assign bank_addr  = reg_addr;
    assign bank_wdata = reg_wdata;

    bwc_decode #(
        .NUM_BANKS (NUM_BANKS),
        .WIN_DEPTH (WIN_DEPTH),
        .SEL_W     (SEL_W)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .cur_bank (cur_bank),
        .region   (region),
        .sel_wr   (sel_wr),
        .bank_wr  (bank_wr)
    );

    bwc_bank_sel #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W)
    ) u_sel (
        .clk      (clk),
        .rst      (rst),
        .sel_wr   (sel_wr),
        .wdata    (reg_wdata),
        .cur_bank (cur_bank)
    );

    bwc_rdmux #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .DEV_REV   (DEV_REV)
    ) u_rdmux (
        .clk        (clk),
        .rst        (rst),
        .rd         (reg_rd),
        .region     (region),
        .cur_bank   (cur_bank),
        .bank_rdata (bank_rdata),
        .rdata      (reg_rdata)
    );

endmodule

// File: tb/sim_bank_window_ctrl.sv
`timescale 1ns/100ps
module sim_bank_window_ctrl;

    localparam int NB  = 5;
    localparam int WIN = 112;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [7:0]    reg_rdata;
    logic [NB-1:0] bank_wr;
    logic [7:0]    bank_addr;
    logic [7:0]    bank_wdata;
    logic [NB*8-1:0] bank_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int exp_bank = 0;

    logic [7:0] mem [NB][WIN];
    logic [7:0] shadow [NB][WIN];

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_pend = 1'b0;

    always #2 clk = ~clk;

    bank_window_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .bank_wr    (bank_wr),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata),
        .bank_rdata (bank_rdata)
    );

    // Bank storage stand-in
    always @(posedge clk) begin
        for (int b = 0; b < NB; b++)
            if (bank_wr[b] && int'(bank_addr) < WIN) mem[b][bank_addr] <= bank_wdata;
    end

    always_comb begin
        for (int b = 0; b < NB; b++)
            bank_rdata[b*8 +: 8] = (int'(bank_addr) < WIN) ? mem[b][bank_addr] : 8'h00;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data against the scoreboard
    always @(posedge clk) rd_pend <= reg_rd;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                check(tag_q.pop_front(), {24'h0, reg_rdata}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic bus_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d,
                          input logic [NB-1:0] exp_strobe, input string tag);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        #1;
        check(tag, {27'h0, bank_wr}, {27'h0, exp_strobe});
        if (exp_strobe != '0) begin
            check({tag, " addr fwd"}, {24'h0, bank_addr}, {24'h0, a});
            check({tag, " data fwd"}, {24'h0, bank_wdata}, {24'h0, d});
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic select(input int b);
        bus_wr(8'hFF, 8'(b), '0, "R2 select strobe-free");
        if (b < NB) exp_bank = b;
    endtask

    task automatic win_wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr(a, d, NB'(1) << exp_bank, "R5 window strobe");
        shadow[exp_bank][a] = d;
    endtask

    initial begin
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < WIN; i++) begin
                mem[b][i]    = 8'h00;
                shadow[b][i] = 8'h00;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1
        check("R1 rdata after reset", {24'h0, reg_rdata}, 32'h0);
        bus_rd(8'hFF, 8'h00, "R1 select after reset");

        // R5/R6: distinct pattern per bank at the same address
        for (int b = 0; b < NB; b++) begin
            select(b);
            bus_rd(8'hFF, 8'(b), "R2 select readback");
            win_wr(8'h10, 8'hA0 + 8'(b));
            win_wr(8'h6F, 8'h3C ^ 8'(b * 17));
        end
        for (int b = NB - 1; b >= 0; b--) begin
            select(b);
            bus_rd(8'h10, shadow[b][8'h10], "R6 bank isolation");
            bus_rd(8'h6F, shadow[b][8'h6F], "R6 window top");
            // R4 in every bank
            bus_rd(8'h7A, 8'h50, "R4 vendor id");
            bus_rd(8'h7B, 8'hC5, "R4 chip id");
            bus_rd(8'h7C, 8'h53, "R4 device id");
        end

        // R3: out-of-range selects ignored
        select(2);
        select(5);
        bus_rd(8'hFF, 8'h02, "R3 value 5 ignored");
        select(8'h82);
        bus_rd(8'hFF, 8'h02, "R3 value 0x82 ignored");
        bus_rd(8'h10, shadow[2][8'h10], "R3 bank kept");
        select(4);
        bus_rd(8'hFF, 8'h04, "R2 top bank");

        // R4: ID writes change nothing
        bus_wr(8'h7A, 8'h00, '0, "R4 id write no strobe");
        bus_wr(8'h7B, 8'h11, '0, "R4 id write no strobe");
        bus_wr(8'h7C, 8'hFF, '0, "R4 id write no strobe");
        bus_rd(8'h7A, 8'h50, "R4 vendor after write");
        bus_rd(8'h7B, 8'hC5, "R4 chip after write");
        bus_rd(8'h7C, 8'h53, "R4 device after write");

        // R7: unimplemented addresses
        bus_wr(8'h70, 8'h99, '0, "R7 unimpl write no strobe");
        bus_wr(8'hFE, 8'h99, '0, "R7 unimpl write no strobe");
        bus_rd(8'h70, 8'h00, "R7 unimpl read 0x70");
        bus_rd(8'hFE, 8'h00, "R7 unimpl read 0xFE");
        bus_rd(8'h7D, 8'h00, "R7 unimpl read 0x7D");

        // R8: 16-bit pair, high byte first
        select(1);
        win_wr(8'h20, 8'hBE);
        win_wr(8'h21, 8'hEF);
        bus_rd(8'h20, 8'hBE, "R8 high byte");
        bus_rd(8'h21, 8'hEF, "R8 low byte");

        // R9: hold without read strobe
        repeat (2) @(negedge clk);
        reg_addr = 8'h7B;
        repeat (3) @(negedge clk);
        check("R9 rdata held", {24'h0, reg_rdata}, 32'hEF);

        repeat (2) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule